// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

The block builds one serial-flash transaction at a time from a small stored program. A configuration port writes a table of sequences. Each sequence is a short run of 16-bit microinstructions. Each microinstruction names an operation, a lane width and an operand. A trigger selects one sequence and supplies the target address and the data byte count. The engine then walks that sequence. For each instruction it presents one phase descriptor on a lane-level phase interface: command, address, dummy, write data or read data. A downstream serializer accepts each descriptor with a ready signal.

The table is guarded by a key-and-lock scheme. Writes to the table take effect only after a correct key write followed by an unlock command. A status flag shows whether the engine is idle. Two sticky flags report an illegal instruction and a trigger that arrived while the engine was busy.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset, idle_o is 1, ph_valid_o is 0, both error flags are 0 and the table is locked. Every table word resets to zero, which is a stop instruction.
- R2: A table write (cfg_sel_i=2, cfg_idx_i = sequence*4 + word) takes effect only while the table is unlocked. The table unlocks when a key write (cfg_sel_i=0, data 0x5AF05AF0) is followed directly by a lock-control write (cfg_sel_i=1) of 0x2. The same two writes with 0x1 lock it again. Any other configuration write between the key and the lock-control write cancels the key.
- R3: An instruction holds the opcode in bits 15:10, the lane code in bits 9:8 and the operand in bits 7:0. ph_lanes_o carries the lane code: 0=1, 1=2, 2=4 and 3=8 lanes. Instructions execute in order, word 0 first, and within a word the low half runs before the high half.
- R4: Opcode 0x01 produces a command phase (ph_kind_o=1) with ph_count_o=8 and ph_data_o set to the operand.
- R5: Opcode 0x02 produces an address phase (ph_kind_o=2). ph_count_o is the operand (the address bit count) and ph_data_o is the trigger address.
- R6: Opcode 0x0C produces a dummy phase (ph_kind_o=3) with ph_count_o equal to the operand. An operand above 64 counts as an illegal instruction.
- R7: Opcode 0x08 produces a write phase (ph_kind_o=4) and 0x09 produces a read phase (ph_kind_o=5). In both, ph_count_o is the trigger byte count and ph_data_o is 0.
- R8: Opcode 0x00 ends the sequence with no phase. After the eighth instruction the sequence also ends, even without a stop.
- R9: Any other opcode sets err_op_o, produces no phase and ends the sequence.
- R10: idle_o goes low in the cycle after an accepted trigger and stays low until the sequence ends. A phase stays valid and stable until ph_ready_i is high.
- R11: A trigger is accepted only while idle_o is 1. A trigger sampled while idle_o is 0 is ignored and sets err_cmd_o. An accepted trigger clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target of the write: 0 key, 1 lock control, 2 table word |
| cfg_idx_i | input | 7 | Table word index, sequence*4 + word |
| cfg_wdata_i | input | 32 | Configuration write data |
| trig_i | input | 1 | Start request |
| trig_seq_i | input | 5 | Sequence to run |
| trig_addr_i | input | 32 | Flash target address |
| trig_len_i | input | 16 | Data byte count |
| ph_valid_o | output | 1 | Phase descriptor valid |
| ph_kind_o | output | 3 | Phase kind: 1 command, 2 address, 3 dummy, 4 write, 5 read |
| ph_lanes_o | output | 2 | Lane code, log2 of the lane count |
| ph_count_o | output | 16 | Bits, cycles or bytes of the phase |
| ph_data_o | output | 32 | Command byte or address |
| ph_ready_i | input | 1 | Phase accepted by the serializer |
| idle_o | output | 1 | Engine idle |
| err_op_o | output | 1 | Illegal instruction seen |
| err_cmd_o | output | 1 | Trigger arrived while busy |

## Verification
A new trigger can arrive in the same cycle the engine decodes the stop that ends the current sequence. idle_o is still low in that cycle, so the trigger must be rejected. The bench provokes this by holding trig_i for two cycles on a sequence that contains only a stop. The second trigger sample lands exactly on the stop decode. The bench then expects err_cmd_o high, idle_o back high and no phase produced. A second collision is a ready stall that lasts across the final phase of a sequence. In that case the descriptor must stay frozen and idle_o must stay low until the handshake completes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [31:0] KEY_VALUE  = 32'h5AF0_5AF0;
  localparam logic [31:0] LOCK_CMD   = 32'h1;
  localparam logic [31:0] UNLOCK_CMD = 32'h2;

  localparam logic [1:0] SEL_KEY  = 2'd0;
  localparam logic [1:0] SEL_LOCK = 2'd1;
  localparam logic [1:0] SEL_TBL  = 2'd2;

  localparam logic [5:0] OP_STOP  = 6'h00;
  localparam logic [5:0] OP_CMD   = 6'h01;
  localparam logic [5:0] OP_ADDR  = 6'h02;
  localparam logic [5:0] OP_WRITE = 6'h08;
  localparam logic [5:0] OP_READ  = 6'h09;
  localparam logic [5:0] OP_DUMMY = 6'h0C;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WRITE = 3'd4,
    PH_READ  = 3'd5
  } phase_e;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] lanes;
    logic [7:0] opnd;
  } instr_t;
endpackage

// File: rtl/seq_lock.sv
module seq_lock
  import flash_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  sel_i,
  input  logic [31:0] wdata_i,
  output logic        tbl_we_o
);
  logic key_ok_q, unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_ok_q   <= 1'b0;
      unlocked_q <= 1'b0;
    end else if (we_i) begin
      // key arms exactly one following write
      key_ok_q <= (sel_i == SEL_KEY) && (wdata_i == KEY_VALUE);
      if (sel_i == SEL_LOCK && key_ok_q) begin
        if (wdata_i == UNLOCK_CMD)    unlocked_q <= 1'b1;
        else if (wdata_i == LOCK_CMD) unlocked_q <= 1'b0;
      end
    end
  end

  assign tbl_we_o = we_i && (sel_i == SEL_TBL) && unlocked_q;

  assert_unlock_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> $past(key_ok_q) && $past(we_i) && $past(sel_i) == SEL_LOCK);
endmodule

// File: rtl/seq_table.sv
module seq_table #(
  parameter int NUM_SEQ       = 32,
  parameter int WORDS_PER_SEQ = 4,
  localparam int DEPTH = NUM_SEQ * WORDS_PER_SEQ,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int WRD_W = $clog2(WORDS_PER_SEQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [31:0]      wdata_i,
  input  logic [SEQ_W-1:0] rd_seq_i,
  input  logic [WRD_W-1:0] rd_word_i,
  output logic [31:0]      rd_data_o
);
  logic [31:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gen_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))         mem[g] <= wdata_i;
    end
  end

  assign rd_data_o = mem[{rd_seq_i, rd_word_i}];
endmodule

// File: rtl/seq_exec.sv
module seq_exec
  import flash_seq_pkg::*;
#(
  parameter int NUM_SEQ       = 32,
  parameter int WORDS_PER_SEQ = 4,
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 16,
  parameter int MAX_DUMMY     = 64,
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int WRD_W = $clog2(WORDS_PER_SEQ),
  localparam int PC_W  = WRD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [SEQ_W-1:0]  trig_seq_i,
  input  logic [ADDR_W-1:0] trig_addr_i,
  input  logic [LEN_W-1:0]  trig_len_i,
  output logic [SEQ_W-1:0]  rd_seq_o,
  output logic [WRD_W-1:0]  rd_word_o,
  input  logic [31:0]       rd_data_i,
  output logic              ph_valid_o,
  output logic [2:0]        ph_kind_o,
  output logic [1:0]        ph_lanes_o,
  output logic [LEN_W-1:0]  ph_count_o,
  output logic [ADDR_W-1:0] ph_data_o,
  input  logic              ph_ready_i,
  output logic              idle_o,
  output logic              err_op_o,
  output logic              err_cmd_o
);
  typedef enum logic [1:0] {S_IDLE, S_DEC, S_PH} state_e;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(2 * WORDS_PER_SEQ - 1);

  state_e            state_q;
  logic [PC_W-1:0]   pc_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  phase_e            kind_q;
  logic [1:0]        lanes_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] data_q;
  logic              err_op_q, err_cmd_q;
  instr_t            ins;

  assign rd_seq_o  = seq_q;
  assign rd_word_o = pc_q[PC_W-1:1];
  assign ins       = pc_q[0] ? rd_data_i[31:16] : rd_data_i[15:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      seq_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      kind_q    <= PH_NONE;
      lanes_q   <= '0;
      cnt_q     <= '0;
      data_q    <= '0;
      err_op_q  <= 1'b0;
      err_cmd_q <= 1'b0;
    end else begin
      if (trig_i && state_q != S_IDLE) err_cmd_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (trig_i) begin
          seq_q     <= trig_seq_i;
          addr_q    <= trig_addr_i;
          len_q     <= trig_len_i;
          pc_q      <= '0;
          err_op_q  <= 1'b0;
          err_cmd_q <= 1'b0;
          state_q   <= S_DEC;
        end
        S_DEC: begin
          lanes_q <= ins.lanes;
          state_q <= S_PH;
          unique case (ins.op)
            OP_STOP: state_q <= S_IDLE;
            OP_CMD: begin
              kind_q <= PH_CMD;
              cnt_q  <= LEN_W'(8);
              data_q <= ADDR_W'(ins.opnd);
            end
            OP_ADDR: begin
              kind_q <= PH_ADDR;
              cnt_q  <= LEN_W'(ins.opnd);
              data_q <= addr_q;
            end
            OP_DUMMY: begin
              if (int'(ins.opnd) > MAX_DUMMY) begin
                err_op_q <= 1'b1;
                state_q  <= S_IDLE;
              end else begin
                kind_q <= PH_DUMMY;
                cnt_q  <= LEN_W'(ins.opnd);
                data_q <= '0;
              end
            end
            OP_WRITE, OP_READ: begin
              kind_q <= (ins.op == OP_WRITE) ? PH_WRITE : PH_READ;
              cnt_q  <= len_q;
              data_q <= '0;
            end
            default: begin
              err_op_q <= 1'b1;
              state_q  <= S_IDLE;
            end
          endcase
        end
        S_PH: if (ph_ready_i) begin
          if (pc_q == PC_LAST) state_q <= S_IDLE;
          else begin
            pc_q    <= pc_q + 1'b1;
            state_q <= S_DEC;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ph_valid_o = (state_q == S_PH);
  assign ph_kind_o  = kind_q;
  assign ph_lanes_o = lanes_q;
  assign ph_count_o = cnt_q;
  assign ph_data_o  = data_q;
  assign idle_o     = (state_q == S_IDLE);
  assign err_op_o   = err_op_q;
  assign err_cmd_o  = err_cmd_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_valid_o && !ph_ready_i) |=> ph_valid_o && $stable(ph_kind_o) && $stable(ph_count_o)
      && $stable(ph_data_o) && $stable(ph_lanes_o));
  assert_busy_while_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_valid_o |-> !idle_o);
  assert_dummy_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_valid_o && ph_kind_o == PH_DUMMY) |-> int'(ph_count_o) <= MAX_DUMMY);
  assert_cmd_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_valid_o && ph_kind_o == PH_CMD) |-> ph_count_o == LEN_W'(8) && ph_data_o[ADDR_W-1:8] == '0);
  assert_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && trig_i) |=> !idle_o && !err_cmd_o && !err_op_o);
  assert_reject_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && trig_i) |=> err_cmd_o);
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int NUM_SEQ       = 32,
  parameter int WORDS_PER_SEQ = 4,
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 16,
  parameter int MAX_DUMMY     = 64,
  localparam int IDX_W = $clog2(NUM_SEQ * WORDS_PER_SEQ),
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int WRD_W = $clog2(WORDS_PER_SEQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              trig_i,
  input  logic [SEQ_W-1:0]  trig_seq_i,
  input  logic [ADDR_W-1:0] trig_addr_i,
  input  logic [LEN_W-1:0]  trig_len_i,
  output logic              ph_valid_o,
  output logic [2:0]        ph_kind_o,
  output logic [1:0]        ph_lanes_o,
  output logic [LEN_W-1:0]  ph_count_o,
  output logic [ADDR_W-1:0] ph_data_o,
  input  logic              ph_ready_i,
  output logic              idle_o,
  output logic              err_op_o,
  output logic              err_cmd_o
);
  logic             tbl_we;
  logic [SEQ_W-1:0] rd_seq;
  logic [WRD_W-1:0] rd_word;
  logic [31:0]      rd_data;

  seq_lock u_lock (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .tbl_we_o (tbl_we)
  );

  seq_table #(.NUM_SEQ(NUM_SEQ), .WORDS_PER_SEQ(WORDS_PER_SEQ)) u_table (
    .clk_i, .rst_ni,
    .we_i      (tbl_we),
    .widx_i    (cfg_idx_i),
    .wdata_i   (cfg_wdata_i),
    .rd_seq_i  (rd_seq),
    .rd_word_i (rd_word),
    .rd_data_o (rd_data)
  );

  seq_exec #(
    .NUM_SEQ(NUM_SEQ), .WORDS_PER_SEQ(WORDS_PER_SEQ), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .MAX_DUMMY(MAX_DUMMY)
  ) u_exec (
    .clk_i, .rst_ni,
    .trig_i, .trig_seq_i, .trig_addr_i, .trig_len_i,
    .rd_seq_o  (rd_seq),
    .rd_word_o (rd_word),
    .rd_data_i (rd_data),
    .ph_valid_o, .ph_kind_o, .ph_lanes_o, .ph_count_o, .ph_data_o,
    .ph_ready_i, .idle_o, .err_op_o, .err_cmd_o
  );
endmodule

// File: tb/sim_flash_seq_engine.sv
module sim_flash_seq_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [6:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        trig = 0;
  logic [4:0]  trig_seq = 0;
  logic [31:0] trig_addr = 0;
  logic [15:0] trig_len = 0;
  logic        rdy = 1;
  logic        ph_valid, idle, err_op, err_cmd;
  logic [2:0]  ph_kind;
  logic [1:0]  ph_lanes;
  logic [15:0] ph_count;
  logic [31:0] ph_data;

  int checks = 0, errors = 0;
  int n_ph = 0;
  logic [2:0]  cap_kind  [16];
  logic [1:0]  cap_lanes [16];
  logic [15:0] cap_cnt   [16];
  logic [31:0] cap_data  [16];

  always #5 clk = ~clk;

  flash_seq_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .trig_i(trig), .trig_seq_i(trig_seq), .trig_addr_i(trig_addr), .trig_len_i(trig_len),
    .ph_valid_o(ph_valid), .ph_kind_o(ph_kind), .ph_lanes_o(ph_lanes),
    .ph_count_o(ph_count), .ph_data_o(ph_data), .ph_ready_i(rdy),
    .idle_o(idle), .err_op_o(err_op), .err_cmd_o(err_cmd)
  );

  always @(negedge clk) if (ph_valid && rdy && n_ph < 16) begin
    cap_kind[n_ph] = ph_kind; cap_lanes[n_ph] = ph_lanes;
    cap_cnt[n_ph] = ph_count; cap_data[n_ph] = ph_data;
    n_ph++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [6:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_lock(input logic [31:0] c);
    cfg(2'd0, 7'd0, 32'h5AF0_5AF0);
    cfg(2'd1, 7'd0, c);
  endtask

  task automatic run(input logic [4:0] s, input int hold);
    @(negedge clk);
    n_ph = 0;
    trig = 1; trig_seq = s; trig_addr = 32'h00AB_CDEF; trig_len = 16'd300;
    for (int i = 0; i < hold; i++) @(negedge clk);
    trig = 0;
    for (int i = 0; i < 200 && !idle; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] instr;
    logic [3:0]  req;
    logic [1:0]  n;
    logic [2:0]  kind;
    logic [1:0]  lanes;
    logic [15:0] cnt;
    logic [31:0] data;
    logic        err;
  } vec_t;

  // kind: 1 cmd, 2 addr, 3 dummy, 4 write, 5 read
  localparam vec_t VECS [9] = '{
    '{16'h049F, 4'd4, 2'd1, 3'd1, 2'd0, 16'd8,   32'h9F,        1'b0}, // R4 cmd 1 lane
    '{16'h0A18, 4'd5, 2'd1, 3'd2, 2'd2, 16'd24,  32'h00AB_CDEF, 1'b0}, // R5 addr 4 lanes
    '{16'h3308, 4'd6, 2'd1, 3'd3, 2'd3, 16'd8,   32'h0,         1'b0}, // R6 dummy 8 lanes
    '{16'h3040, 4'd6, 2'd1, 3'd3, 2'd0, 16'd64,  32'h0,         1'b0}, // R6 limit
    '{16'h3041, 4'd6, 2'd0, 3'd0, 2'd0, 16'd0,   32'h0,         1'b1}, // R6 over limit
    '{16'h2500, 4'd7, 2'd1, 3'd5, 2'd1, 16'd300, 32'h0,         1'b0}, // R7 read
    '{16'h2300, 4'd7, 2'd1, 3'd4, 2'd3, 16'd300, 32'h0,         1'b0}, // R7 write
    '{16'hFC00, 4'd9, 2'd0, 3'd0, 2'd0, 16'd0,   32'h0,         1'b1}, // R9 undefined
    '{16'h0706, 4'd11, 2'd1, 3'd1, 2'd3, 16'd8,  32'h06,        1'b0}  // R11 error cleared
  };

  bit done = 0;
  initial begin
    for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(idle === 1, "R1 idle", 32'(idle), 1);
    check(ph_valid === 0, "R1 valid", 32'(ph_valid), 0);
    check(err_op === 0 && err_cmd === 0, "R1 errors", {err_op, err_cmd}, 0);
    // R1/R2 locked after reset: write ignored, table still all stop
    cfg(2'd2, 7'd20, 32'h0000_049F);
    run(5'd5, 1);
    check(n_ph == 0, "R1 locked at reset", n_ph, 0);

    set_lock(32'h2);
    foreach (VECS[k]) begin
      cfg(2'd2, 7'd20, {16'h0000, VECS[k].instr});
      run(5'd5, 1);
      check(n_ph == int'(VECS[k].n), $sformatf("R%0d phase count", VECS[k].req), n_ph, VECS[k].n);
      check(err_op === VECS[k].err, $sformatf("R%0d err_op", VECS[k].req), 32'(err_op), 32'(VECS[k].err));
      if (VECS[k].n != 0 && n_ph != 0) begin
        check(cap_kind[0] == VECS[k].kind, $sformatf("R%0d kind", VECS[k].req), cap_kind[0], VECS[k].kind);
        check(cap_lanes[0] == VECS[k].lanes, "R3 lanes", cap_lanes[0], VECS[k].lanes);
        check(cap_cnt[0] == VECS[k].cnt, $sformatf("R%0d count", VECS[k].req), cap_cnt[0], VECS[k].cnt);
        check(cap_data[0] == VECS[k].data, $sformatf("R%0d data", VECS[k].req), cap_data[0], VECS[k].data);
      end
    end

    // R3 order and R8 end after eighth instruction: seq 7, cmd operands 0x10..0x17, lanes i%4
    for (int w = 0; w < 4; w++) begin
      logic [15:0] lo, hi;
      lo = {6'h01, 2'(2*w),   8'(8'h10 + 2*w)};
      hi = {6'h01, 2'(2*w+1), 8'(8'h11 + 2*w)};
      cfg(2'd2, 7'(28 + w), {hi, lo});
    end
    run(5'd7, 1);
    check(n_ph == 8, "R8 eight instructions", n_ph, 8);
    check(idle === 1, "R8 idle after eighth", 32'(idle), 1);
    for (int i = 0; i < 8 && i < n_ph; i++) begin
      check(cap_data[i] == 32'(8'h10 + i), "R3 order", cap_data[i], 32'(8'h10 + i));
      check(cap_lanes[i] == 2'(i), "R3 lane code", cap_lanes[i], 32'(i % 4));
    end

    // R8 stop in the middle: word 1 of seq 8 low half stop
    cfg(2'd2, 7'd32, {16'h0422, 16'h0411});
    run(5'd8, 1);
    check(n_ph == 2, "R8 stop ends", n_ph, 2);

    // R2 relock then table write ignored
    set_lock(32'h1);
    cfg(2'd2, 7'd36, 32'h0000_0455);
    run(5'd9, 1);
    check(n_ph == 0, "R2 write while locked", n_ph, 0);
    // R2 key cancelled by intervening write
    cfg(2'd0, 7'd0, 32'h5AF0_5AF0);
    cfg(2'd2, 7'd36, 32'h0000_0455);
    cfg(2'd1, 7'd0, 32'h2);
    cfg(2'd2, 7'd36, 32'h0000_0455);
    run(5'd9, 1);
    check(n_ph == 0, "R2 cancelled key", n_ph, 0);
    // R2 wrong key value
    cfg(2'd0, 7'd0, 32'h5AF0_5AF1);
    cfg(2'd1, 7'd0, 32'h2);
    cfg(2'd2, 7'd36, 32'h0000_0455);
    run(5'd9, 1);
    check(n_ph == 0, "R2 wrong key", n_ph, 0);
    set_lock(32'h2);
    cfg(2'd2, 7'd36, 32'h0000_0455);
    run(5'd9, 1);
    check(n_ph == 1 && cap_data[0] == 32'h55, "R2 unlocked write", cap_data[0], 32'h55);

    // R11 busy trigger ignored, one phase only
    run(5'd9, 2);
    check(err_cmd === 1, "R11 busy trigger flag", 32'(err_cmd), 1);
    check(n_ph == 1, "R11 busy trigger ignored", n_ph, 1);
    run(5'd9, 1);
    check(err_cmd === 0, "R11 cleared on accept", 32'(err_cmd), 0);
    // R11 trigger colliding with stop decode of an empty sequence
    run(5'd10, 2);
    check(err_cmd === 1, "R11 trigger at finish", 32'(err_cmd), 1);
    check(idle === 1 && n_ph == 0, "R11 finish idle", n_ph, 0);

    // R10 stall: descriptor held, idle low
    rdy = 0;
    @(negedge clk);
    trig = 1; trig_seq = 5'd9;
    @(negedge clk);
    trig = 0;
    check(idle === 0, "R10 idle low after trigger", 32'(idle), 0);
    repeat (5) @(negedge clk);
    check(ph_valid === 1 && ph_kind == 3'd1 && ph_data == 32'h55, "R10 held phase", ph_data, 32'h55);
    check(idle === 0, "R10 idle low during stall", 32'(idle), 0);
    n_ph = 0;
    rdy = 1;
    for (int i = 0; i < 50 && !idle; i++) @(negedge clk);
    check(n_ph == 1 && idle === 1, "R10 release", n_ph, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule